// File: doc/BRIEF.md
# BT.656 Video Capture Front End

This block sits directly behind a digital video decoder. It takes the decoder's 4:2:2 byte stream on the 27 MHz sample clock. Line and field timing travel inside the stream and not on separate wires. The block searches the stream for timing reference codes and keeps a running record of the current field, vertical blanking and horizontal blanking state.

After a capture request, the block waits for a clean field boundary. It then copies every active-video byte of one complete frame into the write port of an external FIFO. Each word carries the byte together with a field bit and a line-start bit, so a reader in another clock domain can rebuild the picture. When both fields have been written, the block goes idle and waits for the next request. Bytes that arrive while the FIFO reports full are dropped, and a sticky flag records the loss.

Top module: `bt656_capture`

## Requirements
- R1: A timing code is the byte run all-ones, all-zeros, all-zeros, XY. In XY, bit DATA_W-2 is the field flag F, bit DATA_W-3 is the vertical blanking flag V, and bit DATA_W-4 is H (0 marks start of active video, 1 marks end of active video). The `field`, `vblank` and `hblank` outputs take F, V and H one cycle after the byte that follows XY is sampled.
- R2: With no capture request, `fifo_we` never asserts and `busy` stays low.
- R3: A one-cycle `capture_req` pulse while idle sets `busy` from the next cycle. Writing starts only at the first start-of-active code with F=0 and V=0 that comes after a code with V=1. Active bytes of the frame in progress are not written.
- R4: Only the LINE_BYTES bytes that directly follow a start-of-active code with V=0 count as active video. Timing codes, horizontal blanking bytes and lines with V=1 are never written.
- R5: Each sampled active byte appears on `fifo_wdata` with `fifo_we` high in the cycle after it is sampled, in stream order. The word layout is {field bit, line-start bit, byte}. The field bit is the F of the line, and line-start is 1 only for the first byte of each line.
- R6: Capture ends at the first code with V=1 after at least one F=1 active line has been written. `busy` then drops, and later frames are not written.
- R7: While `fifo_full` is high, `fifo_we` is low and the pending byte is dropped.
- R8: `overflow` sets when a byte is dropped because the FIFO is full. It stays set until the next accepted capture request, which clears it.
- R9: After reset, `busy`, `fifo_we` and `overflow` are 0, `field` is 0, and `vblank` and `hblank` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock of the video byte stream |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_byte | input | DATA_W | Incoming video byte stream |
| capture_req | input | 1 | One-cycle request to capture one frame |
| fifo_full | input | 1 | FIFO full indication |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | DATA_W+2 | {field, line start, byte} FIFO word |
| busy | output | 1 | High from request until the frame is complete |
| overflow | output | 1 | Sticky flag for a byte dropped due to full FIFO |
| field | output | 1 | Current field flag from the last timing code |
| vblank | output | 1 | Current vertical blanking flag |
| hblank | output | 1 | Current horizontal blanking flag |

## Verification
The bench builds the block with DATA_W=8 and LINE_BYTES=8. This shrinks a line to 20 bytes and a frame to 200 bytes, so every byte of six consecutive frames can be predicted and checked. The small size covers a frame streamed with no request, a request made in the middle of an active field, a full capture with one FIFO-full line, the frame after capture ends, and a request that lands on a blanking code. The bench computes the protection bits of each timing code arithmetically, and it tags each expected word from the frame layout it generates.

// File: rtl/bt656_cap_pkg.sv
package bt656_cap_pkg;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_ARMED = 2'd1,
      CS_RUN   = 2'd2
   } cap_state_e;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } trs_flags_t;

endpackage

// File: rtl/bt656_trs_find.sv
module bt656_trs_find
   import bt656_cap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic              trs_stb,
   output trs_flags_t        flags
);
   localparam int DEPTH = 3;
   localparam logic [DATA_W-1:0] ALL_ONE  = '1;
   localparam logic [DATA_W-1:0] ALL_ZERO = '0;

   logic [DATA_W-1:0] hist [DEPTH];
   logic              match;

   // hist[0] is the newest byte
   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_hist
         always_ff @(posedge clk) begin
            if (!rst_n) hist[s] <= '0;
            else if (s == 0) hist[s] <= din;
            else hist[s] <= hist[s-1];
         end
      end
   endgenerate

   assign match = (hist[2] == ALL_ONE) && (hist[1] == ALL_ZERO) && (hist[0] == ALL_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trs_stb <= 1'b0;
         flags   <= '{f: 1'b0, v: 1'b1, h: 1'b1};
      end else begin
         trs_stb <= match;
         if (match) begin
            flags.f <= din[DATA_W-2];
            flags.v <= din[DATA_W-3];
            flags.h <= din[DATA_W-4];
         end
      end
   end
endmodule

// File: rtl/bt656_timing_state.sv
module bt656_timing_state (
   input  logic clk,
   input  logic rst_n,
   input  logic trs_stb,
   input  logic f_in,
   input  logic v_in,
   input  logic h_in,
   output logic field,
   output logic vblank,
   output logic hblank
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field  <= 1'b0;
         vblank <= 1'b1;
         hblank <= 1'b1;
      end else if (trs_stb) begin
         field  <= f_in;
         vblank <= v_in;
         hblank <= h_in;
      end
   end
endmodule

// File: rtl/bt656_line_gate.sv
module bt656_line_gate #(
   parameter int LINE_BYTES = 1440
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trs_stb,
   input  logic f_in,
   input  logic v_in,
   input  logic h_in,
   output logic first_now,
   output logic act_now,
   output logic line_field
);
   localparam int CNT_W = (LINE_BYTES > 2) ? $clog2(LINE_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_REM = CNT_W'(LINE_BYTES - 1);

   logic             in_line_q;
   logic [CNT_W-1:0] rem_q;
   logic             lf_q;

   assign first_now  = trs_stb && !h_in && !v_in;
   assign act_now    = first_now || in_line_q;
   assign line_field = first_now ? f_in : lf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_line_q <= 1'b0;
         rem_q     <= '0;
         lf_q      <= 1'b0;
      end else if (first_now) begin
         in_line_q <= 1'b1;
         rem_q     <= LAST_REM;
         lf_q      <= f_in;
      end else if (in_line_q) begin
         rem_q <= rem_q - 1'b1;
         if (rem_q == CNT_W'(1)) in_line_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bt656_capture_ctrl.sv
module bt656_capture_ctrl
   import bt656_cap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic capture_req,
   input  logic trs_stb,
   input  logic f_in,
   input  logic v_in,
   input  logic first_now,
   output logic gate,
   output logic clr_ovf,
   output logic busy
);
   cap_state_e st_q;
   logic       primed_q;
   logic       seen_f1_q;
   logic       start_hit;

   assign start_hit = (st_q == CS_ARMED) && first_now && primed_q && !f_in;
   assign gate      = (st_q == CS_RUN) || start_hit;
   assign clr_ovf   = (st_q == CS_IDLE) && capture_req;
   assign busy      = (st_q != CS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= CS_IDLE;
         primed_q  <= 1'b0;
         seen_f1_q <= 1'b0;
      end else begin
         unique case (st_q)
            CS_IDLE: begin
               if (capture_req) begin
                  st_q      <= CS_ARMED;
                  primed_q  <= 1'b0;
                  seen_f1_q <= 1'b0;
               end
            end
            CS_ARMED: begin
               if (trs_stb && v_in) primed_q <= 1'b1;
               if (start_hit) st_q <= CS_RUN;
            end
            CS_RUN: begin
               if (first_now && f_in) seen_f1_q <= 1'b1;
               if (trs_stb && v_in && seen_f1_q) st_q <= CS_IDLE;
            end
            default: st_q <= CS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bt656_fifo_stage.sv
module bt656_fifo_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              act_now,
   input  logic              gate,
   input  logic              first_now,
   input  logic              line_field,
   input  logic              fifo_full,
   input  logic              clr_ovf,
   output logic              fifo_we,
   output logic [DATA_W+1:0] fifo_wdata,
   output logic              overflow
);
   logic pend_q;

   assign fifo_we = pend_q && !fifo_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         fifo_wdata <= '0;
         overflow   <= 1'b0;
      end else begin
         pend_q <= act_now && gate;
         if (act_now && gate) fifo_wdata <= {line_field, first_now, din};
         if (clr_ovf) overflow <= 1'b0;
         else if (pend_q && fifo_full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/bt656_capture.sv
module bt656_capture
   import bt656_cap_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 1440
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] vid_byte,
   input  logic              capture_req,
   input  logic              fifo_full,
   output logic              fifo_we,
   output logic [DATA_W+1:0] fifo_wdata,
   output logic              busy,
   output logic              overflow,
   output logic              field,
   output logic              vblank,
   output logic              hblank
);
   generate
      if (DATA_W != 8 && DATA_W != 10) begin : g_bad_width
         $error("bt656_capture: DATA_W must be 8 or 10");
      end
      if (LINE_BYTES < 2) begin : g_bad_line
         $error("bt656_capture: LINE_BYTES must be at least 2");
      end
   endgenerate

   logic       trs_stb;
   trs_flags_t flags;
   logic       first_now, act_now, line_field, gate, clr_ovf;

   bt656_trs_find #(.DATA_W(DATA_W)) u_find (
      .clk(clk), .rst_n(rst_n), .din(vid_byte), .trs_stb(trs_stb), .flags(flags)
   );

   bt656_timing_state u_state (
      .clk(clk), .rst_n(rst_n), .trs_stb(trs_stb),
      .f_in(flags.f), .v_in(flags.v), .h_in(flags.h),
      .field(field), .vblank(vblank), .hblank(hblank)
   );

   bt656_line_gate #(.LINE_BYTES(LINE_BYTES)) u_gate (
      .clk(clk), .rst_n(rst_n), .trs_stb(trs_stb),
      .f_in(flags.f), .v_in(flags.v), .h_in(flags.h),
      .first_now(first_now), .act_now(act_now), .line_field(line_field)
   );

   bt656_capture_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .capture_req(capture_req), .trs_stb(trs_stb),
      .f_in(flags.f), .v_in(flags.v), .first_now(first_now),
      .gate(gate), .clr_ovf(clr_ovf), .busy(busy)
   );

   bt656_fifo_stage #(.DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .din(vid_byte), .act_now(act_now), .gate(gate),
      .first_now(first_now), .line_field(line_field), .fifo_full(fifo_full),
      .clr_ovf(clr_ovf), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .overflow(overflow)
   );
endmodule

// File: rtl/bt656_capture_chk.sv
module bt656_capture_chk (
   input logic clk,
   input logic rst_n,
   input logic capture_req,
   input logic fifo_full,
   input logic fifo_we,
   input logic busy,
   input logic overflow
);
   // R2
   busy_we_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_we |-> busy);

   // R7
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !fifo_we);

   // R8
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !capture_req) |=> overflow);

   // R8
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(fifo_full));

   // R3
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(capture_req));
endmodule

bind bt656_capture bt656_capture_chk u_chk (
   .clk(clk), .rst_n(rst_n), .capture_req(capture_req), .fifo_full(fifo_full),
   .fifo_we(fifo_we), .busy(busy), .overflow(overflow)
);

// File: tb/bt656_capture_bench.sv
module bt656_capture_bench;
   localparam int DW = 8;
   localparam int LB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] vid_byte = '0;
   logic          capture_req = 1'b0;
   logic          fifo_full = 1'b0;
   logic          fifo_we, busy, overflow, field, vblank, hblank;
   logic [DW+1:0] fifo_wdata;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   bit    prv_wr = 0;
   logic [DW+1:0] prv_w = '0;
   string prv_tag = "R9";
   string idle_tag = "R2";
   bit    full_r = 0;
   int    lc = 0;

   always #10 clk = ~clk;

   bt656_capture #(.DATA_W(DW), .LINE_BYTES(LB)) u_bt656_capture (
      .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte), .capture_req(capture_req),
      .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .busy(busy),
      .overflow(overflow), .field(field), .vblank(vblank), .hblank(hblank)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic send_byte(input logic [7:0] b, input bit wr, input logic [DW+1:0] w,
                            input bit req);
      @(negedge clk);
      if (prv_wr)
         chk(fifo_we === 1'b1 && fifo_wdata === prv_w, prv_tag,
             int'({fifo_we, fifo_wdata}), int'({1'b1, prv_w}));
      else
         chk(fifo_we === 1'b0, prv_tag, int'(fifo_we), 0);
      vid_byte    = b;
      capture_req = req;
      fifo_full   = full_r;
      prv_wr      = wr && !full_r;
      prv_w       = w;
      prv_tag     = wr ? (full_r ? "R7" : "R5") : idle_tag;
   endtask

   task automatic send_line(input bit f, input bit v, input bit cap, input bit req,
                            input bit full);
      logic [7:0] hb [4] = '{8'h80, 8'h10, 8'h80, 8'h10};
      send_byte(8'hFF, 0, '0, req);
      send_byte(8'h00, 0, '0, 0);
      send_byte(8'h00, 0, '0, 0);
      send_byte(xy(f, v, 1'b1), 0, '0, 0);
      for (int i = 0; i < 4; i++) send_byte(hb[i], 0, '0, 0);
      // R1: end-of-active code seen, horizontal blanking flagged
      chk(hblank === 1'b1 && field === f && vblank === v, "R1",
          int'({field, vblank, hblank}), int'({f, v, 1'b1}));
      send_byte(8'hFF, 0, '0, 0);
      send_byte(8'h00, 0, '0, 0);
      send_byte(8'h00, 0, '0, 0);
      send_byte(xy(f, v, 1'b0), 0, '0, 0);
      full_r = full;
      for (int i = 0; i < LB; i++) begin
         logic [7:0] d;
         d = 8'h21 + 8'((lc * LB + i) % 200);
         send_byte(d, cap && !v, {f, (i == 0), d}, 0);
         if (i == 2)
            chk(hblank === 1'b0 && field === f && vblank === v, "R1",
                int'({field, vblank, hblank}), int'({f, v, 1'b0}));
      end
      full_r = 0;
      lc++;
   endtask

   // lines 0-1: F=0 blank, 2-4: F=0 active, 5-6: F=1 blank, 7-9: F=1 active
   task automatic send_frame(input bit cap, input int req_line, input int full_line);
      for (int ln = 0; ln < 10; ln++) begin
         send_line(ln >= 5, (ln % 5) < 2, cap, ln == req_line, ln == full_line);
         if (ln == req_line) begin
            chk(busy === 1'b1, "R3", int'(busy), 1);
            chk(overflow === 1'b0, "R8", int'(overflow), 0);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(busy === 1'b0 && fifo_we === 1'b0 && overflow === 1'b0, "R9",
          int'({busy, fifo_we, overflow}), 0);
      chk(field === 1'b0 && vblank === 1'b1 && hblank === 1'b1, "R9",
          int'({field, vblank, hblank}), 3);
      rst_n = 1'b1;

      idle_tag = "R2";
      send_frame(0, -1, -1);
      chk(busy === 1'b0, "R2", int'(busy), 0);

      idle_tag = "R3";
      send_frame(0, 3, -1);

      idle_tag = "R4";
      send_frame(1, -1, 8);
      chk(overflow === 1'b1, "R8", int'(overflow), 1);

      idle_tag = "R6";
      send_line(0, 1, 0, 0, 0);
      chk(busy === 1'b0, "R6", int'(busy), 0);
      send_line(0, 1, 0, 0, 0);
      for (int ln = 2; ln < 10; ln++) send_line(ln >= 5, (ln % 5) < 2, 0, 0, 0);
      chk(overflow === 1'b1, "R8", int'(overflow), 1);

      idle_tag = "R4";
      send_frame(1, 0, -1);
      idle_tag = "R6";
      send_line(0, 1, 0, 0, 0);
      chk(busy === 1'b0, "R6", int'(busy), 0);
      send_line(0, 1, 0, 0, 0);
      send_line(0, 0, 0, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule